// File: doc/BRIEF.md
# Per-Line Event Interrupt Detector

This block watches a bank of already-synchronized input lines and turns chosen events on them into a single interrupt request for the whole bank. Each line has its own 3-bit selector, supplied from outside as a packed vector. The selector picks one of five event kinds: a falling edge, a rising edge, either edge, a low level or a high level. Edges are found by comparing each line with the value it had one clock earlier. A detected event latches into a per-line status bit. That bit is set whether or not the line is enabled for interrupts.

Software reaches the block over a simple register bus with a select, a write flag, an address and data. Enable and disable registers set or clear bits of a read-only mask. The status register is cleared by the act of reading it, so no acknowledge write exists. The interrupt output is high while any status bit is set together with its mask bit. The data width of the bus equals the number of lines.

Top module: `lineevt_irq`

## Requirements
- R1: While reset is low, and on leaving it, the mask, the status bits and the per-line edge history are all zero, and `irqOut` is low. A read of either register during reset returns zero.
- R2: Selector code 0 sets a line's status bit on a 1-to-0 change of that line, code 1 on a 0-to-1 change, and code 2 on either change. A change is seen between the samples of two consecutive clocks. The status bit is visible on the bus in the cycle after the clock edge that sampled the new value.
- R3: Selector code 3 sets the status bit on every clock where the line is 0, and code 4 on every clock where it is 1. A bit cleared by a read therefore reappears one clock later if the level still holds.
- R4: Selector codes 5, 6 and 7 never set the status bit, whatever the line does.
- R5: A bus write to offset 0x20 sets every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R6: A bus write to offset 0x24 clears every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R7: A read at offset 0x28 returns the mask. A write to 0x28 or to 0x2C changes neither the mask nor the status.
- R8: A read at offset 0x2C returns the status bits and clears them all on that clock. Status bits are set regardless of the mask.
- R9: If an event arrives on the clock of a status read, the read returns the value without it, and the new event stays set after the read.
- R10: `irqOut` is high exactly when some line has both its status bit and its mask bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | LINES | Synchronized line levels |
| evtSel | input | 3*LINES | Per-line event selector, line i at bits [3i+2:3i] |
| busSel | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | LINES | Write data, one bit per line |
| busRdata | output | LINES | Read data, valid in the access cycle |
| irqOut | output | 1 | Bank interrupt request |

## Verification
The bench builds the block with LINES = 8 and ADDR_W = 8. Line i is given selector code i. Eight lines then cover all five event kinds and all three unused codes side by side, so one table of line patterns exercises every selector against the same stimulus. The narrow width keeps each expected status word small enough to work out by hand. It also leaves the read-clear collision and the level re-set after a read within a few directed cycles.

// File: rtl/lineevt_pkg.sv
package lineevt_pkg;

  typedef enum logic [2:0] {
    EV_FALL = 3'd0,
    EV_RISE = 3'd1,
    EV_BOTH = 3'd2,
    EV_LOW  = 3'd3,
    EV_HIGH = 3'd4
  } evt_kind_e;

  localparam int OFS_ENABLE  = 'h20;
  localparam int OFS_DISABLE = 'h24;
  localparam int OFS_MASK    = 'h28;
  localparam int OFS_STATUS  = 'h2C;
  localparam int SEL_W       = 3;

  typedef struct packed {
    logic setMask;
    logic clrMask;
    logic rdMask;
    logic rdStat;
  } strobe_t;

endpackage

// File: rtl/lineevt_detect.sv
module lineevt_detect
  import lineevt_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             cur,
  input  logic             prev,
  output logic             hit
);
  always_comb begin
    case (sel)
      EV_FALL: hit = prev & ~cur;
      EV_RISE: hit = ~prev & cur;
      EV_BOTH: hit = prev ^ cur;
      EV_LOW:  hit = ~cur;
      EV_HIGH: hit = cur;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/lineevt_ctrl.sv
module lineevt_ctrl
  import lineevt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_DIS = ADDR_W'(OFS_DISABLE);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFS_STATUS);

  logic wrCyc;
  logic rdCyc;

  assign wrCyc = busSel & busWrite;
  assign rdCyc = busSel & ~busWrite;

  always_comb begin
    strb         = '0;
    strb.setMask = wrCyc && (busAddr == A_EN);
    strb.clrMask = wrCyc && (busAddr == A_DIS);
    strb.rdMask  = rdCyc && (busAddr == A_MSK);
    strb.rdStat  = rdCyc && (busAddr == A_STS);
  end
endmodule

// File: rtl/lineevt_datapath.sv
module lineevt_datapath
  import lineevt_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [LINES-1:0]       lineIn,
  input  logic [SEL_W*LINES-1:0] evtSel,
  input  logic [LINES-1:0]       wrData,
  input  strobe_t                strb,
  output logic [LINES-1:0]       rdData,
  output logic                   irqOut
);
  logic [LINES-1:0] prevLine;
  logic [LINES-1:0] evtVec;
  logic [LINES-1:0] maskReg;
  logic [LINES-1:0] statusReg;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    lineevt_detect u_det (
      .sel  (evtSel[SEL_W*g +: SEL_W]),
      .cur  (lineIn[g]),
      .prev (prevLine[g]),
      .hit  (evtVec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevLine <= '0;
    else       prevLine <= lineIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             maskReg <= '0;
    else if (strb.setMask) maskReg <= maskReg | wrData;
    else if (strb.clrMask) maskReg <= maskReg & ~wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            statusReg <= '0;
    else if (strb.rdStat) statusReg <= evtVec;
    else                  statusReg <= statusReg | evtVec;
  end

  always_comb begin
    rdData = '0;
    if (strb.rdMask)      rdData = maskReg;
    else if (strb.rdStat) rdData = statusReg;
  end

  assign irqOut = |(statusReg & maskReg);

  p_enable_sets_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.setMask |=> ((maskReg & $past(wrData)) == $past(wrData)));

  p_disable_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrMask |=> ((maskReg & $past(wrData)) == '0));

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.setMask || strb.clrMask) |=> $stable(maskReg));

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStat && evtVec == '0) |=> (statusReg == '0));

  p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdStat |=> ((statusReg & $past(statusReg)) == $past(statusReg)));
endmodule

// File: rtl/lineevt_irq.sv
module lineevt_irq
  import lineevt_pkg::*;
#(
  parameter int LINES  = 32,
  parameter int ADDR_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [LINES-1:0]       lineIn,
  input  logic [SEL_W*LINES-1:0] evtSel,
  input  logic                   busSel,
  input  logic                   busWrite,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [LINES-1:0]       busWdata,
  output logic [LINES-1:0]       busRdata,
  output logic                   irqOut
);
  strobe_t strb;

  lineevt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb)
  );

  lineevt_datapath #(.LINES(LINES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .lineIn (lineIn),
    .evtSel (evtSel),
    .wrData (busWdata),
    .strb   (strb),
    .rdData (busRdata),
    .irqOut (irqOut)
  );
endmodule

// File: tb/lineevt_irq_tb.sv
module lineevt_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 8;
  localparam int ADDR_W = 8;
  localparam int NVEC = 6;
  // {line pattern, expected status read after it settles one clock}
  localparam logic [15:0] VECS [NVEC] = '{
    16'h17_1E, 16'h08_1D, 16'hE8_00, 16'hEE_06, 16'hE1_0C, 16'hE1_08
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [LINES-1:0] lineIn = '0;
  logic [3*LINES-1:0] evtSel;
  logic busSel = 1'b0;
  logic busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [LINES-1:0] busWdata = '0;
  logic [LINES-1:0] busRdata;
  logic irqOut;

  int nChecks = 0;
  int nErrors = 0;
  logic [LINES-1:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  lineevt_irq #(.LINES(LINES), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .evtSel(evtSel),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] addr, input logic [LINES-1:0] data);
    busSel = 1'b1; busWrite = 1'b1; busAddr = addr; busWdata = data;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic busRd(input logic [7:0] addr, output logic [LINES-1:0] data);
    busSel = 1'b1; busWrite = 1'b0; busAddr = addr;
    #1 data = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nErrors++;
    nChecks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < LINES; i++) evtSel[3*i +: 3] = 3'(i);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 irq in reset", 32'(irqOut), 0);
    busSel = 1'b1; busAddr = 8'h28; #1 chk("R1 mask in reset", 32'(busRdata), 0);
    busAddr = 8'h2C; #1 chk("R1 status in reset", 32'(busRdata), 0);
    busSel = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1/R3: no edge from cleared history, only the low-level line
    busRd(8'h2C, rd); chk("R1 R3 status after reset", 32'(rd), 32'h08);

    // R2 R3 R4: table of line patterns
    for (int k = 0; k < NVEC; k++) begin
      lineIn = VECS[k][15:8];
      @(negedge clk);
      chk("R8 unmasked status keeps irq low", 32'(irqOut), 0);
      busRd(8'h2C, rd);
      chk("R2 R3 R4 table status", 32'(rd), 32'(VECS[k][7:0]));
    end

    // R3: level gone, status drains to zero
    lineIn = 8'h08;
    @(negedge clk);
    busRd(8'h2C, rd);
    busRd(8'h2C, rd); chk("R3 no level no status", 32'(rd), 0);

    // R5 R6 R7: mask registers
    busWr(8'h20, 8'h05);
    busRd(8'h28, rd); chk("R5 enable sets", 32'(rd), 32'h05);
    busWr(8'h20, 8'h02);
    busRd(8'h28, rd); chk("R5 zero bits keep", 32'(rd), 32'h07);
    busWr(8'h24, 8'h04);
    busRd(8'h28, rd); chk("R6 disable clears", 32'(rd), 32'h03);
    busWr(8'h28, 8'hFF);
    busRd(8'h28, rd); chk("R7 mask write ignored", 32'(rd), 32'h03);
    busWr(8'h2C, 8'hFF);
    busRd(8'h2C, rd); chk("R7 status write ignored", 32'(rd), 0);

    // R10: masked event raises irq, read drops it
    chk("R10 irq idle", 32'(irqOut), 0);
    lineIn = 8'h0A;
    @(negedge clk);
    chk("R10 irq raised", 32'(irqOut), 1);
    busRd(8'h2C, rd); chk("R8 read returns event", 32'(rd), 32'h02);
    chk("R10 irq dropped after read", 32'(irqOut), 0);
    lineIn = 8'h0E;
    @(negedge clk);
    chk("R10 unmasked line no irq", 32'(irqOut), 0);
    busRd(8'h2C, rd); chk("R2 both-edge rise", 32'(rd), 32'h04);

    // R9: event on the read clock
    lineIn = 8'h0A;
    busRd(8'h2C, rd); chk("R9 read returns old", 32'(rd), 0);
    busRd(8'h2C, rd); chk("R9 new event kept", 32'(rd), 32'h04);

    // R3 R10: persistent high level re-sets after read
    busWr(8'h20, 8'h10);
    lineIn = 8'h1A;
    @(negedge clk);
    chk("R10 level irq", 32'(irqOut), 1);
    busRd(8'h2C, rd); chk("R3 high level status", 32'(rd), 32'h10);
    chk("R3 level reappears", 32'(irqOut), 1);
    lineIn = 8'h0A;
    @(negedge clk);
    busRd(8'h2C, rd); chk("R3 last level kept", 32'(rd), 32'h10);
    busRd(8'h2C, rd); chk("R3 level released", 32'(rd), 0);
    chk("R10 irq low at end", 32'(irqOut), 0);

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule